// File: doc/BRIEF.md
# Single-Accumulator Processor with Shared Memory Port

This block is a small processor built around one accumulator register. Instructions and data live in the same memory and travel over one synchronous port of 16-bit words, so a control state machine takes turns using that port for instruction fetch and for operand reads and writes. Each instruction word has an opcode in its upper byte and an 8-bit address or branch target in its lower byte.

Arithmetic and logic instructions take the accumulator as an implicit first operand and a memory word as the second, and write the result back to the accumulator. Zero and negative flags record the last value written to the accumulator, and conditional branches test them. The block is used by attaching a memory with one cycle of read latency, loading a program at address 0 and releasing reset.

Top module: `acc_cpu`

## Requirements
- R1: While rst_n is low at a rising edge, the program counter, accumulator and both flags are cleared and the machine enters an initialize state with both strobes low; one cycle after reset is released it fetches from address 0.
- R2: A fetch asserts mem_rd with mem_addr equal to the program counter, and read data is captured on the cycle after the strobe; mem_rd is never high in two consecutive cycles and mem_rd and mem_wr are never high together.
- R3: Bits 15:8 of an instruction hold the opcode and bits 7:0 hold the operand address or branch target.
- R4: LOAD (opcode 0x01) reads the word at the operand address and puts it in the accumulator.
- R5: STORE (opcode 0x02) asserts mem_wr at the operand address with the accumulator on mem_wdata and leaves the accumulator unchanged.
- R6: ADD (0x03) sets the accumulator to accumulator plus memory word and SUB (0x04) to accumulator minus memory word, both modulo 2^16.
- R7: AND (0x05) and OR (0x06) combine the accumulator with the memory word bit by bit.
- R8: The zero flag (result is 0) and negative flag (bit 15 of the result) change only on LOAD, ADD, SUB, AND and OR; STORE, branches and no-ops keep them.
- R9: BRZ (0x07) loads the program counter with the target when the zero flag is set, BRN (0x08) when the negative flag is set, JMP (0x09) always; an untaken branch and every other instruction advance the program counter by one.
- R10: HALT (0x0F) stops the machine with no further memory access until reset.
- R11: Any other opcode is a no-op that only advances the program counter.
- R12: A LOAD or ALU instruction takes six cycles, a STORE four and a branch three; with LOAD at address 0 followed by STORE, the operand read comes four cycles and the write ten cycles after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 8 | Word address for the current access |
| mem_rd | output | 1 | Read strobe; data returns on mem_rdata the next cycle |
| mem_wr | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | 16 | Store data (accumulator) |
| mem_rdata | input | 16 | Read data from memory |

## Verification
The shared port is the point where two functions meet: a STORE's write and the following instruction fetch fall in adjacent cycles on the same address and strobe wires, and a flag update in one instruction's execute cycle is consumed by the very next branch's decode. Programs chain LOAD, an ALU operation, STORE and back-to-back BRZ/BRN, so a result is written and then immediately steers control flow. The outcome is judged by where the result lands in the modelled memory, by strobe positions cycle by cycle, and by a running count of cycles with both strobes high.

// File: rtl/acc_cpu_pkg.sv
// Package: shared opcodes, FSM states and ALU operation codes for acc_cpu.
// Assumes an 8-bit opcode field; the top module narrows or widens it by cast.
package acc_cpu_pkg;

    localparam logic [7:0] OPC_LOAD  = 8'h01;
    localparam logic [7:0] OPC_STORE = 8'h02;
    localparam logic [7:0] OPC_ADD   = 8'h03;
    localparam logic [7:0] OPC_SUB   = 8'h04;
    localparam logic [7:0] OPC_AND   = 8'h05;
    localparam logic [7:0] OPC_OR    = 8'h06;
    localparam logic [7:0] OPC_BRZ   = 8'h07;
    localparam logic [7:0] OPC_BRN   = 8'h08;
    localparam logic [7:0] OPC_JMP   = 8'h09;
    localparam logic [7:0] OPC_HALT  = 8'h0F;

    typedef enum logic [3:0] {
        S_INIT,
        S_FETCH,
        S_FWAIT,
        S_DECODE,
        S_OPRD,
        S_OPWAIT,
        S_EXEC,
        S_STORE,
        S_HALT
    } state_t;

    typedef enum logic [2:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR
    } alu_op_t;

endpackage

// File: rtl/acc_cpu_alu.sv
// ALU: combines accumulator (a) with memory operand (b) and reports
// zero and negative status of the result. Purely combinational.
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_t        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           zero,
    output logic           neg
);

    // Result select by operation
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = b;
        endcase
    end

    // Status of the result
    always_comb begin
        zero = (y == '0);
        neg  = y[W-1];
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
// Control FSM: sequences init, fetch, decode and the three execute paths
// (operand load / ALU, store, branch) over one shared memory port.
// Assumes memory read data is valid one cycle after the read strobe and
// that the opcode input is stable from decode until execute ends.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  logic            z_flag,
    input  logic            n_flag,
    output state_t          state_o,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            addr_ir,
    output logic            ld_ir,
    output logic            ld_reg,
    output logic            ld_ac,
    output logic            pc_inc,
    output logic            pc_load,
    output alu_op_t         alu_op
);

    localparam logic [OP_W-1:0] C_LOAD  = OP_W'(OPC_LOAD);
    localparam logic [OP_W-1:0] C_STORE = OP_W'(OPC_STORE);
    localparam logic [OP_W-1:0] C_ADD   = OP_W'(OPC_ADD);
    localparam logic [OP_W-1:0] C_SUB   = OP_W'(OPC_SUB);
    localparam logic [OP_W-1:0] C_AND   = OP_W'(OPC_AND);
    localparam logic [OP_W-1:0] C_OR    = OP_W'(OPC_OR);
    localparam logic [OP_W-1:0] C_BRZ   = OP_W'(OPC_BRZ);
    localparam logic [OP_W-1:0] C_BRN   = OP_W'(OPC_BRN);
    localparam logic [OP_W-1:0] C_JMP   = OP_W'(OPC_JMP);
    localparam logic [OP_W-1:0] C_HALT  = OP_W'(OPC_HALT);

    state_t state_q, state_d;

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_INIT;
        else        state_q <= state_d;
    end

    // Operation select for the ALU from the opcode
    always_comb begin
        unique case (opcode)
            C_ADD:   alu_op = ALU_ADD;
            C_SUB:   alu_op = ALU_SUB;
            C_AND:   alu_op = ALU_AND;
            C_OR:    alu_op = ALU_OR;
            default: alu_op = ALU_PASS;
        endcase
    end

    // Next state and control strobes
    always_comb begin
        state_d = state_q;
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        addr_ir = 1'b0;
        ld_ir   = 1'b0;
        ld_reg  = 1'b0;
        ld_ac   = 1'b0;
        pc_inc  = 1'b0;
        pc_load = 1'b0;
        unique case (state_q)
            S_INIT:   state_d = S_FETCH;
            S_FETCH: begin
                mem_rd  = 1'b1;
                state_d = S_FWAIT;
            end
            S_FWAIT: begin
                ld_ir   = 1'b1;
                state_d = S_DECODE;
            end
            S_DECODE: begin
                state_d = S_FETCH;
                unique case (opcode)
                    C_LOAD, C_ADD, C_SUB, C_AND, C_OR: state_d = S_OPRD;
                    C_STORE: state_d = S_STORE;
                    C_BRZ: begin
                        pc_load = z_flag;
                        pc_inc  = !z_flag;
                    end
                    C_BRN: begin
                        pc_load = n_flag;
                        pc_inc  = !n_flag;
                    end
                    C_JMP:  pc_load = 1'b1;
                    C_HALT: state_d = S_HALT;
                    default: pc_inc = 1'b1;
                endcase
            end
            S_OPRD: begin
                mem_rd  = 1'b1;
                addr_ir = 1'b1;
                state_d = S_OPWAIT;
            end
            S_OPWAIT: begin
                ld_reg  = 1'b1;
                state_d = S_EXEC;
            end
            S_EXEC: begin
                ld_ac   = 1'b1;
                pc_inc  = 1'b1;
                state_d = S_FETCH;
            end
            S_STORE: begin
                mem_wr  = 1'b1;
                addr_ir = 1'b1;
                pc_inc  = 1'b1;
                state_d = S_FETCH;
            end
            S_HALT:  state_d = S_HALT;
            default: state_d = S_INIT;
        endcase
    end

    assign state_o = state_q;

    // R2: the port is never read and written in the same cycle
    a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R2: every read is followed by a data-capture cycle without a read
    a_r2_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R10: halt is left only through reset and makes no access
    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT) |=> (state_q == S_HALT) && !mem_rd && !mem_wr);

endmodule

// File: rtl/acc_cpu.sv
// Top: accumulator datapath (PC, IR, REG, AC, flags, address mux) with the
// control FSM and ALU. One synchronous memory port with one-cycle read
// latency serves fetch and operand access alike.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int OP_W = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] reg_q;
    logic [DATA_W-1:0] ac_q;
    logic              z_q, n_q;

    state_t            state;
    alu_op_t           alu_op;
    logic              addr_ir, ld_ir, ld_reg, ld_ac, pc_inc, pc_load;
    logic [DATA_W-1:0] alu_y;
    logic              alu_zero, alu_neg;

    acc_cpu_ctrl #(.OP_W(OP_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .opcode  (ir_q[DATA_W-1:ADDR_W]),
        .z_flag  (z_q),
        .n_flag  (n_q),
        .state_o (state),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr),
        .addr_ir (addr_ir),
        .ld_ir   (ld_ir),
        .ld_reg  (ld_reg),
        .ld_ac   (ld_ac),
        .pc_inc  (pc_inc),
        .pc_load (pc_load),
        .alu_op  (alu_op)
    );

    acc_cpu_alu #(.W(DATA_W)) u_alu (
        .op   (alu_op),
        .a    (ac_q),
        .b    (reg_q),
        .y    (alu_y),
        .zero (alu_zero),
        .neg  (alu_neg)
    );

    // Program counter: clear, jump to target, or step
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= '0;
        else if (pc_load) pc_q <= ir_q[ADDR_W-1:0];
        else if (pc_inc)  pc_q <= pc_q + 1'b1;
    end

    // Instruction and operand registers capture delayed read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            reg_q <= '0;
        end else begin
            if (ld_ir)  ir_q  <= mem_rdata;
            if (ld_reg) reg_q <= mem_rdata;
        end
    end

    // Accumulator and its status flags, written together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q <= '0;
            z_q  <= 1'b0;
            n_q  <= 1'b0;
        end else if (ld_ac) begin
            ac_q <= alu_y;
            z_q  <= alu_zero;
            n_q  <= alu_neg;
        end
    end

    // Address multiplexer in place of a separate address register
    always_comb begin
        mem_addr  = addr_ir ? ir_q[ADDR_W-1:0] : pc_q;
        mem_wdata = ac_q;
    end

    // R1: reset clears the architectural state and selects init
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0) && (ac_q == '0) && !z_q && !n_q && (state == S_INIT));

    // R8: flags move only in a cycle that writes the accumulator
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_ac |=> $stable({z_q, n_q}));

    // R9: stepping instructions advance the PC by exactly one
    a_r9_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC || state == S_STORE) |=> pc_q == ADDR_W'($past(pc_q) + 1'b1));

    // R9: an unconditional jump lands on the instruction's target field
    a_r9_jmp_target: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE && ir_q[DATA_W-1:ADDR_W] == OP_W'(OPC_JMP))
        |=> pc_q == $past(ir_q[ADDR_W-1:0]));

endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

    localparam logic [15:0] SENT = 16'hDEAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    logic [15:0] mem [256];
    int          n_chk = 0;
    int          n_err = 0;
    int          both_cnt = 0;
    int          acc_cnt = 0;

    always #2 clk = ~clk;

    acc_cpu u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // Memory model: one-cycle read latency, plus port usage counters
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd && mem_wr) both_cnt <= both_cnt + 1;
        if (mem_rd || mem_wr) acc_cnt <= acc_cnt + 1;
    end

    // op, operand A (loaded), operand B
    localparam logic [39:0] VEC [8] = '{
        {8'h03, 16'h0005, 16'h0007},
        {8'h03, 16'hFFFF, 16'h0001},
        {8'h04, 16'h0003, 16'h0005},
        {8'h04, 16'h0009, 16'h0009},
        {8'h05, 16'hF0F0, 16'h0FF0},
        {8'h05, 16'hF0F0, 16'h0F0F},
        {8'h06, 16'h8000, 16'h0001},
        {8'h06, 16'h1200, 16'h0034}
    };

    function automatic logic [15:0] model(input logic [7:0] op, input logic [15:0] a, b);
        case (op)
            8'h03:   return a + b;
            8'h04:   return a - b;
            8'h05:   return a & b;
            default: return a | b;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[8'h22] = SENT;
        mem[8'h23] = SENT;
        mem[8'h24] = SENT;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int k_wr;
        int snap;
        // ---- Reset state, R1 ----
        hold_reset();
        chk("R1 rd low in reset", {15'd0, mem_rd}, 16'd0);
        chk("R1 wr low in reset", {15'd0, mem_wr}, 16'd0);

        // ---- Vector table: ALU ops, flags, branches (R3 R4 R6 R7 R8 R9) ----
        foreach (VEC[v]) begin
            logic [7:0]  op;
            logic [15:0] a, b, e;
            op = VEC[v][39:32];
            a  = VEC[v][31:16];
            b  = VEC[v][15:0];
            e  = model(op, a, b);
            hold_reset();
            clear_mem();
            mem[0] = 16'h0120;            // LOAD 0x20
            mem[1] = {op, 8'h21};         // op 0x21
            mem[2] = 16'h0222;            // STORE 0x22
            mem[3] = 16'h0706;            // BRZ 6
            mem[4] = 16'h0808;            // BRN 8
            mem[5] = 16'h0F00;            // HALT
            mem[6] = 16'h0223;            // STORE 0x23
            mem[7] = 16'h0F00;
            mem[8] = 16'h0224;            // STORE 0x24
            mem[9] = 16'h0F00;
            mem[8'h20] = a;
            mem[8'h21] = b;
            rst_n = 1'b1;
            repeat (60) @(negedge clk);
            chk($sformatf("R3 R4 R6 R7 result vec%0d", v), mem[8'h22], e);
            chk($sformatf("R8 R9 BRZ path vec%0d", v), mem[8'h23], (e == 16'h0) ? e : SENT);
            chk($sformatf("R8 R9 BRN path vec%0d", v), mem[8'h24], e[15] ? e : SENT);
        end

        // ---- Timing of strobes, R2 R12, then halt R10 ----
        hold_reset();
        clear_mem();
        mem[0] = 16'h0120;
        mem[1] = 16'h0221;
        mem[2] = 16'h0F00;
        mem[8'h20] = 16'h4321;
        rst_n = 1'b1;
        k_wr = -1;
        for (int k = 0; k <= 12; k++) begin
            if (k == 0) chk("R1 init no read", {15'd0, mem_rd}, 16'd0);
            if (k == 1) begin
                chk("R1 R2 first fetch rd", {15'd0, mem_rd}, 16'd1);
                chk("R1 R2 first fetch addr", {8'd0, mem_addr}, 16'h0000);
            end
            if (k == 2) chk("R2 wait after read", {15'd0, mem_rd}, 16'd0);
            if (k == 4) begin
                chk("R12 operand read rd", {15'd0, mem_rd}, 16'd1);
                chk("R12 operand read addr", {8'd0, mem_addr}, 16'h0020);
            end
            if (mem_wr && k_wr < 0) k_wr = k;
            @(negedge clk);
        end
        chk("R12 store cycle", 16'(k_wr), 16'd10);
        repeat (10) @(negedge clk);
        chk("R4 R5 stored load value", mem[8'h21], 16'h4321);
        snap = acc_cnt;
        repeat (20) @(negedge clk);
        chk("R10 no access after halt", 16'(acc_cnt - snap), 16'd0);

        // ---- Reset clears AC and flags even after a run, R1 ----
        hold_reset();
        clear_mem();
        mem[0] = 16'h0222;                // STORE 0x22
        mem[1] = 16'h0704;                // BRZ 4
        mem[2] = 16'h0223;
        mem[3] = 16'h0F00;
        mem[4] = 16'h0224;
        mem[5] = 16'h0F00;
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk("R1 AC cleared", mem[8'h22], 16'h0000);
        chk("R1 Z cleared so BRZ falls through", mem[8'h23], 16'h0000);
        chk("R1 R9 BRZ not taken", mem[8'h24], SENT);

        // ---- Undefined opcode is a no-op, R11 R8 ----
        hold_reset();
        clear_mem();
        mem[0] = 16'h0120;                // LOAD 0x20 (negative)
        mem[1] = 16'h5500;                // undefined
        mem[2] = 16'h0804;                // BRN 4
        mem[3] = 16'h0F00;
        mem[4] = 16'h0222;
        mem[5] = 16'h0F00;
        mem[8'h20] = 16'h8000;
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        chk("R11 R8 no-op keeps AC and N", mem[8'h22], 16'h8000);

        // ---- STORE keeps AC and Z, R5 R8 ----
        hold_reset();
        clear_mem();
        mem[0] = 16'h0120;                // LOAD 0 -> Z
        mem[1] = 16'h0221;                // STORE 0x21
        mem[2] = 16'h0704;                // BRZ 4
        mem[3] = 16'h0F00;
        mem[4] = 16'h0222;
        mem[5] = 16'h0F00;
        mem[8'h21] = 16'h7777;
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        chk("R5 store wrote AC", mem[8'h21], 16'h0000);
        chk("R5 R8 Z kept across store", mem[8'h22], 16'h0000);

        // ---- JMP skips code, R9 ----
        hold_reset();
        clear_mem();
        mem[0] = 16'h0905;                // JMP 5
        mem[1] = 16'h0222;                // skipped
        mem[5] = 16'h0120;
        mem[6] = 16'h0223;
        mem[7] = 16'h0F00;
        mem[8'h20] = 16'h0ABC;
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk("R9 JMP skipped store", mem[8'h22], SENT);
        chk("R9 JMP target executed", mem[8'h23], 16'h0ABC);

        chk("R2 never read and write together", 16'(both_cnt), 16'd0);

        summary();
        $finish;
    end

endmodule